// File: doc/BRIEF.md
# Warp Issue Scheduler

This block sits in front of the SIMD lanes of a multithreaded processor core and decides, one slot at a time, which resident warp sends its next instruction to the lanes. Every warp keeps its own program counter. It also presents its next instruction's source and destination register numbers on a per-warp field set. A per-warp register scoreboard holds one pending bit for each architectural register of each warp. A warp may issue only when neither of its source registers is pending. Warps never share registers, so hazards are tracked only inside a warp.

Among the warps that are ready, the winner is chosen round-robin, searching upward from the warp after the one that issued most recently. A warp has more threads than there are physical lanes, so an issued instruction holds the lanes for WARP_THREADS/LANES cycles. No other instruction can issue during that time. On issue the destination register of the chosen warp is marked pending. A writeback port naming a warp and a register clears that mark again. Fetch, decode and the execution units are outside the block.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset, issue_valid, issue_warp and issue_pc are zero, no register of any warp is pending, every warp program counter is zero, and the first search starts at warp 0.
- R2: A warp is ready when its inst_valid bit is 1 and neither of its source registers is pending. The fields of warp w are bits [w*REG_W +: REG_W] of the source and destination vectors. An issue decided at clock edge t is visible on issue_* from edge t until edge t+1.
- R3: When several warps are ready, the winner is the first ready warp found by searching upward with wraparound, starting at the warp after the last issued warp. The last issued warp itself has the lowest priority.
- R4: An issue marks the destination register of the issued warp as pending. A pending register of one warp never blocks any other warp.
- R5: A writeback (wb_valid=1) clears the pending mark for register wb_reg of warp wb_warp at the clock edge, so a warp waiting on that register can issue at the next edge. If an issue marks the same warp and register at the same edge, the register stays pending.
- R6: After an issue, no other issue takes place for the following OCC-1 cycles, where OCC = WARP_THREADS/LANES. Two issues are therefore at least OCC cycles apart.
- R7: In a slot with no issue, whether because no warp is ready or because the lanes are busy, issue_valid, issue_warp and issue_pc are all zero, and the round-robin start point does not change.
- R8: issue_pc is the program counter of the issued warp. That counter then advances by one, wrapping at PC_W bits. Issuing one warp does not change the counters of the other warps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inst_valid | input | NUM_WARPS | Per-warp flag: the next instruction is present |
| inst_src_a | input | NUM_WARPS*REG_W | First source register number of each warp |
| inst_src_b | input | NUM_WARPS*REG_W | Second source register number of each warp |
| inst_dst | input | NUM_WARPS*REG_W | Destination register number of each warp |
| wb_valid | input | 1 | Writeback strobe |
| wb_warp | input | WID_W | Warp that the writeback belongs to |
| wb_reg | input | REG_W | Register that the writeback completes |
| issue_valid | output | 1 | An instruction issues in this slot |
| issue_warp | output | WID_W | Warp that issues |
| issue_pc | output | PC_W | Program counter of the issued instruction |

## Verification
A scoreboard bit that is stuck or lost shows up as a warp that never issues again, or that issues over an unfinished writeback. The model sees this in the first slot where that warp's eligibility counts. A wrong round-robin pointer changes which warp is named on issue_warp in the next contested slot. An off-by-one lane timer moves every later issue by a cycle, so the cycle-exact comparison reports it at the second issue. Program counter errors appear on issue_pc the next time the affected warp issues.

// File: rtl/wis_pkg.sv
package wis_pkg;

   // Adds a step to an index and wraps it once into the range 0..modulus-1.
   function automatic int wrap_add(input int base, input int step, input int modulus);
      int s;
      s = base + step;
      if (s >= modulus) s = s - modulus;
      return s;
   endfunction

endpackage

// File: rtl/wis_scoreboard.sv
module wis_scoreboard #(
   parameter int NUM_WARPS = 8,
   parameter int NUM_REGS  = 16
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_WARPS-1:0]              inst_valid,
   input  logic [NUM_WARPS*$clog2(NUM_REGS)-1:0] src_a,
   input  logic [NUM_WARPS*$clog2(NUM_REGS)-1:0] src_b,
   input  logic                              set_en,
   input  logic [$clog2(NUM_WARPS)-1:0]      set_warp,
   input  logic [$clog2(NUM_REGS)-1:0]       set_reg,
   input  logic                              clr_en,
   input  logic [$clog2(NUM_WARPS)-1:0]      clr_warp,
   input  logic [$clog2(NUM_REGS)-1:0]       clr_reg,
   output logic [NUM_WARPS-1:0]              ready,
   output logic [NUM_WARPS*NUM_REGS-1:0]     pend_flat
);
   localparam int WW = $clog2(NUM_WARPS);
   localparam int RW = $clog2(NUM_REGS);

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
      logic [NUM_REGS-1:0] pend;
      logic [RW-1:0]       sa, sb;

      assign sa = src_a[w*RW +: RW];
      assign sb = src_b[w*RW +: RW];

      // Clear first, set second: a same-edge issue keeps the bit pending.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend <= '0;
         end else begin
            if (clr_en && clr_warp == WW'(w)) pend[clr_reg] <= 1'b0;
            if (set_en && set_warp == WW'(w)) pend[set_reg] <= 1'b1;
         end
      end

      assign ready[w] = inst_valid[w] & ~pend[sa] & ~pend[sb];
      assign pend_flat[w*NUM_REGS +: NUM_REGS] = pend;
   end

   // R4: an issue leaves its destination marked
   a_r4_set_marks: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> pend_flat[$past(set_warp)*NUM_REGS + $past(set_reg)]);

   // R5: a writeback clears its register unless the same edge re-marks it
   a_r5_wb_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !(set_en && set_warp == clr_warp && set_reg == clr_reg))
      |=> !pend_flat[$past(clr_warp)*NUM_REGS + $past(clr_reg)]);

endmodule

// File: rtl/wis_rr_pick.sv
module wis_rr_pick #(
   parameter int NUM_WARPS = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_WARPS-1:0]         req,
   input  logic                         adv,
   output logic                         grant_valid,
   output logic [$clog2(NUM_WARPS)-1:0] grant_idx
);
   localparam int WW = $clog2(NUM_WARPS);

   logic [WW-1:0] last_q;

   // Scan from farthest to nearest so the nearest ready warp after last_q wins.
   always_comb begin
      grant_valid = 1'b0;
      grant_idx   = '0;
      for (int k = NUM_WARPS; k >= 1; k--) begin
         int cand;
         cand = wis_pkg::wrap_add(int'(last_q), k, NUM_WARPS);
         if (req[WW'(cand)]) begin
            grant_valid = 1'b1;
            grant_idx   = WW'(cand);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   last_q <= WW'(NUM_WARPS - 1);
      else if (adv) last_q <= grant_idx;
   end

   // R7: no issue, no movement of the start point
   a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(last_q));

   // R3: with competition, the last issued warp is not picked again
   a_r3_skip_last: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && $countones(req) > 1) |-> (grant_idx != last_q));

endmodule

// File: rtl/wis_lane_timer.sv
module wis_lane_timer #(
   parameter int OCC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic free
);
   if (OCC == 1) begin : g_single
      logic unused_timer;
      assign unused_timer = ^{clk, rst_n, start};
      assign free = 1'b1;
   end else begin : g_count
      localparam int CW = $clog2(OCC);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           cnt <= '0;
         else if (start)       cnt <= CW'(OCC - 1);
         else if (cnt != '0)   cnt <= cnt - 1'b1;
      end

      assign free = (cnt == '0);
   end

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
   parameter int NUM_WARPS    = 8,
   parameter int NUM_REGS     = 16,
   parameter int WARP_THREADS = 32,
   parameter int LANES        = 8,
   parameter int PC_W         = 16
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic [NUM_WARPS-1:0]                  inst_valid,
   input  logic [NUM_WARPS*$clog2(NUM_REGS)-1:0] inst_src_a,
   input  logic [NUM_WARPS*$clog2(NUM_REGS)-1:0] inst_src_b,
   input  logic [NUM_WARPS*$clog2(NUM_REGS)-1:0] inst_dst,
   input  logic                                  wb_valid,
   input  logic [$clog2(NUM_WARPS)-1:0]          wb_warp,
   input  logic [$clog2(NUM_REGS)-1:0]           wb_reg,
   output logic                                  issue_valid,
   output logic [$clog2(NUM_WARPS)-1:0]          issue_warp,
   output logic [PC_W-1:0]                       issue_pc
);
   localparam int WW  = $clog2(NUM_WARPS);
   localparam int RW  = $clog2(NUM_REGS);
   localparam int OCC = WARP_THREADS / LANES;
   localparam int GW  = $clog2(OCC + 1) + 1;

   if (NUM_WARPS < 2 || NUM_WARPS > 64) begin : g_bad_warps
      $error("NUM_WARPS must lie in 2..64");
   end
   if (NUM_REGS < 2) begin : g_bad_regs
      $error("NUM_REGS must be at least 2");
   end
   if (LANES < 1 || WARP_THREADS < LANES || (WARP_THREADS % LANES) != 0) begin : g_bad_lanes
      $error("WARP_THREADS must be a positive multiple of LANES");
   end

   logic [NUM_WARPS-1:0]          ready;
   logic [NUM_WARPS*NUM_REGS-1:0] pend_flat;
   logic                          grant_valid;
   logic [WW-1:0]                 grant_idx;
   logic                          lanes_free;
   logic                          fire;
   logic [RW-1:0]                 grant_dst;
   logic [RW-1:0]                 issue_dst_q;
   logic [PC_W-1:0]               pc_r [NUM_WARPS];

   assign grant_dst = inst_dst[grant_idx*RW +: RW];
   assign fire      = grant_valid & lanes_free;

   wis_scoreboard #(.NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS)) u_sb (
      .clk       (clk),
      .rst_n     (rst_n),
      .inst_valid(inst_valid),
      .src_a     (inst_src_a),
      .src_b     (inst_src_b),
      .set_en    (fire),
      .set_warp  (grant_idx),
      .set_reg   (grant_dst),
      .clr_en    (wb_valid),
      .clr_warp  (wb_warp),
      .clr_reg   (wb_reg),
      .ready     (ready),
      .pend_flat (pend_flat)
   );

   wis_rr_pick #(.NUM_WARPS(NUM_WARPS)) u_pick (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (ready),
      .adv        (fire),
      .grant_valid(grant_valid),
      .grant_idx  (grant_idx)
   );

   wis_lane_timer #(.OCC(OCC)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .start(fire),
      .free (lanes_free)
   );

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_pc
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            pc_r[w] <= '0;
         else if (fire && grant_idx == WW'(w))  pc_r[w] <= pc_r[w] + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         issue_valid <= 1'b0;
         issue_warp  <= '0;
         issue_pc    <= '0;
         issue_dst_q <= '0;
      end else if (fire) begin
         issue_valid <= 1'b1;
         issue_warp  <= grant_idx;
         issue_pc    <= pc_r[grant_idx];
         issue_dst_q <= grant_dst;
      end else begin
         issue_valid <= 1'b0;
         issue_warp  <= '0;
         issue_pc    <= '0;
         issue_dst_q <= '0;
      end
   end

   // Cycles since the previous visible issue, saturating at OCC (checker only).
   logic [GW-1:0] gap_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 gap_q <= GW'(OCC);
      else if (issue_valid)       gap_q <= GW'(1);
      else if (gap_q < GW'(OCC))  gap_q <= gap_q + 1'b1;
   end

   // R6: lane occupancy spaces issues at least OCC cycles apart
   a_r6_issue_gap: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> (gap_q >= GW'(OCC)));

   // R2: the picker only grants a warp the scoreboard calls ready
   a_r2_grant_ready: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> ready[grant_idx]);

   // R4: the issued warp's destination is pending while the slot is shown
   a_r4_dst_marked: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> pend_flat[issue_warp*NUM_REGS + issue_dst_q]);

endmodule

// File: tb/tb_warp_issue_sched.sv
module tb_warp_issue_sched;
   localparam int NW   = 8;
   localparam int NR   = 16;
   localparam int RW   = 4;
   localparam int WW   = 3;
   localparam int PCW  = 16;
   localparam int OCC  = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NW-1:0]     inst_valid = '0;
   logic [NW*RW-1:0]  inst_src_a = '0;
   logic [NW*RW-1:0]  inst_src_b = '0;
   logic [NW*RW-1:0]  inst_dst = '0;
   logic              wb_valid = 1'b0;
   logic [WW-1:0]     wb_warp = '0;
   logic [RW-1:0]     wb_reg = '0;
   logic              issue_valid;
   logic [WW-1:0]     issue_warp;
   logic [PCW-1:0]    issue_pc;

   always #2 clk = ~clk;

   warp_issue_sched #(.NUM_WARPS(NW), .NUM_REGS(NR), .WARP_THREADS(32),
                      .LANES(8), .PC_W(PCW)) dut (.*);

   int n_checks = 0;
   int n_fail   = 0;

   // Reference state built from the requirements
   bit            m_pend [NW][NR];
   int            m_last;
   int            m_busy;
   int            m_pc [NW];
   bit            e_valid;
   int            e_warp;
   int            e_pc;
   string         e_tag;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      foreach (m_pend[w, r]) m_pend[w][r] = 1'b0;
      foreach (m_pc[w]) m_pc[w] = 0;
      m_last = NW - 1;
      m_busy = 0;
      e_valid = 1'b0; e_warp = 0; e_pc = 0; e_tag = "R1";
   endtask

   // Computes the slot decided at the coming edge from the present inputs.
   task automatic model_edge();
      bit elig [NW];
      bit any;
      int win;
      any = 1'b0; win = 0;
      for (int w = 0; w < NW; w++) begin
         int sa, sb;
         sa = int'(inst_src_a[w*RW +: RW]);
         sb = int'(inst_src_b[w*RW +: RW]);
         elig[w] = inst_valid[w] && !m_pend[w][sa] && !m_pend[w][sb];
      end
      for (int k = 1; k <= NW; k++) begin
         int c;
         c = (m_last + k) % NW;
         if (!any && elig[c]) begin any = 1'b1; win = c; end
      end
      if (wb_valid) m_pend[int'(wb_warp)][int'(wb_reg)] = 1'b0;
      if (any && m_busy == 0) begin
         e_valid = 1'b1; e_warp = win; e_pc = m_pc[win]; e_tag = "R3";
         m_pc[win] = (m_pc[win] + 1) % (1 << PCW);
         m_last = win;
         m_busy = OCC - 1;
         m_pend[win][int'(inst_dst[win*RW +: RW])] = 1'b1;
      end else begin
         e_tag = (m_busy != 0) ? "R6" : "R7";
         e_valid = 1'b0; e_warp = 0; e_pc = 0;
         if (m_busy != 0) m_busy = m_busy - 1;
      end
   endtask

   // One clock: predict, let the edge pass, compare at the falling edge.
   task automatic step();
      model_edge();
      @(negedge clk);
      check(issue_valid == e_valid, (e_valid ? "R2" : e_tag), int'(issue_valid), int'(e_valid));
      if (e_valid) begin
         check(int'(issue_warp) == e_warp, "R3", int'(issue_warp), e_warp);
         check(int'(issue_pc) == e_pc, "R8", int'(issue_pc), e_pc);
      end else begin
         check(issue_warp == '0 && issue_pc == '0, "R7", int'(issue_pc), 0);
      end
   endtask

   task automatic set_warp(input int w, input bit v, input int sa, input int sb, input int d);
      inst_valid[w] = v;
      inst_src_a[w*RW +: RW] = RW'(sa);
      inst_src_b[w*RW +: RW] = RW'(sb);
      inst_dst[w*RW +: RW]   = RW'(d);
   endtask

   initial begin
      int n_issue;
      int last_at;
      bit seen;
      void'($urandom(32'h0051_D0E5));
      model_reset();
      repeat (3) @(negedge clk);
      // R1: reset state on the outputs
      check(issue_valid == 1'b0 && issue_warp == '0 && issue_pc == '0, "R1",
            int'(issue_pc), 0);
      rst_n = 1'b1;

      // Directed: all warps ready, no hazards -> 0,1,..,7 every OCC cycles (R1 R3 R6 R8)
      for (int w = 0; w < NW; w++) set_warp(w, 1'b1, 0, 0, 1);
      n_issue = 0; last_at = -OCC;
      for (int c = 0; c < 2 * NW * OCC; c++) begin
         step();
         if (issue_valid) begin
            check(int'(issue_warp) == n_issue % NW, "R3", int'(issue_warp), n_issue % NW);
            check(int'(issue_pc) == n_issue / NW, "R8", int'(issue_pc), n_issue / NW);
            if (n_issue > 0) check(c - last_at == OCC, "R6", c - last_at, OCC);
            last_at = c;
            n_issue++;
         end
      end
      check(n_issue == 2 * NW, "R1", n_issue, 2 * NW);

      // Directed: warp 3 blocked by its own pending r1 (R2); warp 4 reads r9 marked by warp 3 (R4)
      for (int w = 0; w < NW; w++) set_warp(w, 1'b0, 0, 0, 0);
      set_warp(3, 1'b1, 1, 2, 9);
      repeat (6) begin
         step();
         check(issue_valid == 1'b0, "R2", int'(issue_valid), 0);
      end
      // R5: writeback of r1 for warp 3 unblocks it
      wb_valid = 1'b1; wb_warp = 3'd3; wb_reg = 4'd1;
      step();
      wb_valid = 1'b0;
      seen = 1'b0;
      repeat (3) begin
         step();
         if (issue_valid && issue_warp == 3'd3) seen = 1'b1;
      end
      check(seen, "R5", int'(seen), 1);
      set_warp(3, 1'b1, 9, 9, 2);   // now waits on its own r9
      set_warp(4, 1'b1, 9, 9, 5);   // another warp's r9 does not matter
      seen = 1'b0;
      repeat (2 * OCC) begin
         step();
         if (issue_valid) begin
            check(issue_warp == 3'd4, "R4", int'(issue_warp), 4);
            seen = 1'b1;
         end
      end
      check(seen, "R4", int'(seen), 1);

      // Directed: nothing valid -> idle slots, start point kept (R7)
      for (int w = 0; w < NW; w++) set_warp(w, 1'b0, 0, 0, 0);
      repeat (8) begin
         step();
         check(issue_valid == 1'b0, "R7", int'(issue_valid), 0);
      end
      set_warp(0, 1'b1, 3, 3, 3);
      set_warp(6, 1'b1, 3, 3, 3);
      step();
      check(issue_valid && issue_warp == 3'd6, "R7", int'(issue_warp), 6);

      // Random traffic with writebacks, including same-edge set and clear (R5)
      for (int c = 0; c < 4000; c++) begin
         for (int w = 0; w < NW; w++)
            set_warp(w, ($urandom_range(0, 9) != 0), $urandom_range(0, 7),
                     $urandom_range(0, 7), $urandom_range(0, 7));
         wb_valid = ($urandom_range(0, 9) < 7);
         wb_warp  = WW'($urandom_range(0, NW - 1));
         wb_reg   = RW'($urandom_range(0, 7));
         step();
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 4);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule